// File: doc/BRIEF.md
# Write-Only Serial Control Register Bank

This block is a three-wire serial slave that fills a bank of sixteen 4-bit control registers. A host pulls the active-low chip select, sends eight bits on the serial data line with one rising serial-clock edge per bit (most significant bit first), and releases chip select. The first four bits sent name the register and the last four bits carry the new value. The write takes effect only when chip select rises after exactly eight clock edges. The registers are write-only, and every stored value is always visible on a flat parallel bus. Downstream logic uses this bus directly.

The three serial lines are asynchronous to the system clock. Each line is brought into the system clock domain by a chain of flops, and the serial-clock and chip-select edges are detected there. Two addresses are reserved. Address 0 is a no-operation. Address 15 is a command that reloads every register with its default. A power-loss input has the same effect at any time.

One register, address 13, holds a mask bit, a loudhearing bit, a handsfree bit and a hook bit. A small decoder turns these four bits into an operating mode and a power-down flag.

Top module: `serial_ctrl_bank`

## Requirements
- R1: After reset, every 4-bit field of `regs_flat` holds its default. Register n sits at bits [4n+3:4n]. The defaults are register 4 = 8, 6 = 0xA, 7 = 3, 8 = 0xB, 9 = 2, 10 = 7, 11 = 7, and 0 for all others. `op_mode` reads 1 (handset) and `pwr_down` reads 0.
- R2: A frame is written as follows. Chip select goes low, eight rising serial-clock edges follow, and chip select goes high. The first bit is frame bit 7 and the last is bit 0. Bits 7:4 select the register and bits 3:0 become its value, visible on `regs_flat` within 8 system clocks of the chip-select rise.
- R3: A frame with a bit count other than eight (for example 7 or 9) changes no register.
- R4: A frame addressed to register 0 changes no output.
- R5: A frame addressed to register 15 returns every register to its default, whatever its data bits are.
- R6: While `pwr_lost` is high at a clock edge, all registers return to their defaults. A frame in progress at that time is dropped.
- R7: When bit 3 (the mask bit) of register 13 is 1, `op_mode` is 0 (power down) and `pwr_down` is 1. This holds whatever the other bits are.
- R8: When the mask bit is 0, the mode comes from the other bits of register 13 (bit 2 loudhearing, bit 1 handsfree, bit 0 hook). Handsfree=1 and loudhearing=0 gives mode 2 (handsfree). Handsfree=1 and loudhearing=1 gives mode 3 (loudhearing). Handsfree=0 and hook=0 gives mode 1 (handset). Handsfree=0 and hook=1 gives mode 0 with `pwr_down`=1.
- R9: Serial-clock edges while chip select is high shift nothing. They change no output, and a following correct frame is written normally.
- R10: Writing a register with the value it already holds leaves all outputs unchanged.
- R11: A write changes only the addressed register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_lost | input | 1 | Synchronous supply-loss indication; reloads defaults |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, sampled on serial-clock rise |
| ser_cs_n | input | 1 | Active-low chip select framing one write |
| regs_flat | output | 64 | All sixteen registers, register n at [4n+3:4n] |
| op_mode | output | 2 | 0 power down, 1 handset, 2 handsfree, 3 loudhearing |
| pwr_down | output | 1 | High when the decoded mode is power down |

## Verification
Frames are sent to several different addresses with data values that have alternating and asymmetric bit patterns. A bit-order or address/data swap therefore shows up as a wrong field on the bus. Frames of seven and nine bits separate an exact-count commit from an at-least-eight commit. Serial-clock toggles with chip select high show whether the bit counter is held idle between frames. Writes to the no-operation address and to the restore address are sent after other registers have been changed, so they can be told apart from one another and from a plain write. All mode combinations of register 13 are walked through, including the disallowed one (handsfree=0, hook=1) and the mask bit combined with every other bit.

// File: rtl/scb_pkg.sv
package scb_pkg;

   typedef enum logic [1:0] {
      MODE_PDOWN     = 2'd0,
      MODE_HANDSET   = 2'd1,
      MODE_HANDSFREE = 2'd2,
      MODE_LOUDHEAR  = 2'd3
   } op_mode_e;

   localparam int unsigned ADDR_W_DEF = 4;
   localparam int unsigned DATA_W_DEF = 4;
   localparam logic [63:0] DEFAULTS_DEF = 64'h0000_772B_3A08_0000;

endpackage

// File: rtl/scb_sync.sv
module scb_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("scb_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d_async};
   end

   assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/scb_shifter.sv
module scb_shifter #(
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              sck_s,
   input  logic              sdi_s,
   input  logic              csn_s,
   output logic              commit,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   localparam int unsigned FRAME   = ADDR_W + DATA_W;
   localparam int unsigned CNT_W   = $clog2(FRAME + 2);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME);
   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME + 1);

   logic             sck_d, csn_d;
   logic [FRAME-1:0] shreg;
   logic [CNT_W-1:0] cnt;
   logic             sck_rise, cs_rise;

   generate
      if (FRAME < 2) begin : g_bad_frame
         $error("scb_shifter: frame must hold at least two bits");
      end
   endgenerate

   assign sck_rise = sck_s & ~sck_d;
   assign cs_rise  = csn_s & ~csn_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d <= 1'b0;
         csn_d <= 1'b1;
         shreg <= '0;
         cnt   <= '0;
      end else begin
         sck_d <= sck_s;
         csn_d <= csn_s;
         if (flush || csn_s) begin
            cnt <= '0;
         end else if (sck_rise) begin
            shreg <= {shreg[FRAME-2:0], sdi_s};
            if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
         end
      end
   end

   assign commit  = cs_rise & ~flush & (cnt == CNT_FULL);
   assign wr_addr = shreg[FRAME-1:DATA_W];
   assign wr_data = shreg[DATA_W-1:0];
endmodule

// File: rtl/scb_regfile.sv
module scb_regfile #(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 4,
   parameter int unsigned NOP_ADDR = 0,
   parameter int unsigned RST_ADDR = 15,
   parameter logic [(2**ADDR_W)*DATA_W-1:0] DEFAULTS = '0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              pwr_lost,
   input  logic                              commit,
   input  logic [ADDR_W-1:0]                 wr_addr,
   input  logic [DATA_W-1:0]                 wr_data,
   output logic [(2**ADDR_W)*DATA_W-1:0]     regs_flat
);
   localparam int unsigned NREGS = 2 ** ADDR_W;

   logic [DATA_W-1:0] regs_q [NREGS];
   logic              restore;

   assign restore = pwr_lost | (commit & (wr_addr == ADDR_W'(RST_ADDR)));

   generate
      if (NOP_ADDR >= NREGS || RST_ADDR >= NREGS || NOP_ADDR == RST_ADDR) begin : g_bad_addr
         $error("scb_regfile: reserved addresses out of range or equal");
      end
      for (genvar i = 0; i < NREGS; i++) begin : g_reg
         localparam logic [DATA_W-1:0] DEF = DEFAULTS[i*DATA_W +: DATA_W];
         if (i == NOP_ADDR || i == RST_ADDR) begin : g_fixed
            assign regs_q[i] = DEF;
         end else begin : g_store
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)                                    regs_q[i] <= DEF;
               else if (restore)                              regs_q[i] <= DEF;
               else if (commit && wr_addr == ADDR_W'(i))      regs_q[i] <= wr_data;
            end
         end
         assign regs_flat[i*DATA_W +: DATA_W] = regs_q[i];
      end
   endgenerate
endmodule

// File: rtl/scb_mode_dec.sv
module scb_mode_dec #(
   parameter int unsigned DATA_W   = 4,
   parameter int unsigned MASK_BIT = 3,
   parameter int unsigned LH_BIT   = 2,
   parameter int unsigned HF_BIT   = 1,
   parameter int unsigned HOOK_BIT = 0
) (
   input  logic [DATA_W-1:0] mode_reg,
   output logic [1:0]        op_mode,
   output logic              pwr_down
);
   import scb_pkg::*;

   op_mode_e m;
   logic mask, lh, hf, hook;

   generate
      if (MASK_BIT >= DATA_W || LH_BIT >= DATA_W || HF_BIT >= DATA_W || HOOK_BIT >= DATA_W)
      begin : g_bad_bits
         $error("scb_mode_dec: control bit positions exceed register width");
      end
   endgenerate

   assign mask = mode_reg[MASK_BIT];
   assign lh   = mode_reg[LH_BIT];
   assign hf   = mode_reg[HF_BIT];
   assign hook = mode_reg[HOOK_BIT];

   always_comb begin
      if (mask)      m = MODE_PDOWN;
      else if (hf)   m = lh ? MODE_LOUDHEAR : MODE_HANDSFREE;
      else if (hook) m = MODE_PDOWN;
      else           m = MODE_HANDSET;
   end

   assign op_mode  = m;
   assign pwr_down = mask | (~hf & hook);
endmodule

// File: rtl/serial_ctrl_bank.sv
module serial_ctrl_bank #(
   parameter int unsigned ADDR_W      = scb_pkg::ADDR_W_DEF,
   parameter int unsigned DATA_W      = scb_pkg::DATA_W_DEF,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned NOP_ADDR    = 0,
   parameter int unsigned RST_ADDR    = 15,
   parameter int unsigned MODE_ADDR   = 13,
   parameter logic [(2**ADDR_W)*DATA_W-1:0] DEFAULTS = scb_pkg::DEFAULTS_DEF
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          pwr_lost,
   input  logic                          ser_clk,
   input  logic                          ser_dat,
   input  logic                          ser_cs_n,
   output logic [(2**ADDR_W)*DATA_W-1:0] regs_flat,
   output logic [1:0]                    op_mode,
   output logic                          pwr_down
);
   localparam int unsigned NREGS = 2 ** ADDR_W;

   logic              sck_s, sdi_s, csn_s;
   logic              commit;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;

   generate
      if (MODE_ADDR >= NREGS || MODE_ADDR == NOP_ADDR || MODE_ADDR == RST_ADDR) begin : g_bad_mode
         $error("serial_ctrl_bank: MODE_ADDR must be a storing register");
      end
   endgenerate

   scb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d_async(ser_clk), .q_sync(sck_s));
   scb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .d_async(ser_dat), .q_sync(sdi_s));
   scb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
      .clk(clk), .rst_n(rst_n), .d_async(ser_cs_n), .q_sync(csn_s));

   scb_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .flush(pwr_lost),
      .sck_s(sck_s), .sdi_s(sdi_s), .csn_s(csn_s),
      .commit(commit), .wr_addr(wr_addr), .wr_data(wr_data));

   scb_regfile #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NOP_ADDR(NOP_ADDR),
      .RST_ADDR(RST_ADDR), .DEFAULTS(DEFAULTS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .pwr_lost(pwr_lost), .commit(commit),
      .wr_addr(wr_addr), .wr_data(wr_data), .regs_flat(regs_flat));

   scb_mode_dec #(.DATA_W(DATA_W)) u_mode (
      .mode_reg(regs_flat[MODE_ADDR*DATA_W +: DATA_W]),
      .op_mode(op_mode), .pwr_down(pwr_down));
endmodule

// File: rtl/serial_ctrl_bank_chk.sv
module serial_ctrl_bank_chk #(
   parameter int unsigned WIDTH     = 64,
   parameter int unsigned DATA_W    = 4,
   parameter int unsigned MODE_ADDR = 13,
   parameter logic [WIDTH-1:0] DEFAULTS = '0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_lost,
   input logic             ser_cs_n,
   input logic [WIDTH-1:0] regs_flat,
   input logic [1:0]       op_mode,
   input logic             pwr_down
);
   logic [3:0] since_rise;
   logic [3:0] high_cnt;
   logic       cs_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev    <= 1'b1;
         since_rise <= 4'hF;
         high_cnt   <= 4'h0;
      end else begin
         cs_prev <= ser_cs_n;
         if (ser_cs_n && !cs_prev)   since_rise <= 4'h0;
         else if (since_rise != 4'hF) since_rise <= since_rise + 4'h1;
         if (!ser_cs_n)               high_cnt <= 4'h0;
         else if (high_cnt != 4'hF)   high_cnt <= high_cnt + 4'h1;
      end
   end

   // R2
   write_after_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(regs_flat) && !$past(pwr_lost)) |-> (since_rise <= 4'd6));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (high_cnt >= 4'd8 && !$past(pwr_lost)) |-> $stable(regs_flat));

   // R6
   pwr_loss_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_lost |=> (regs_flat == DEFAULTS));

   // R7
   mask_forces_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      regs_flat[MODE_ADDR*DATA_W + 3] |-> (pwr_down && op_mode == 2'd0));

   // R8
   mode_flag_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_mode == 2'd0) == pwr_down);
endmodule

bind serial_ctrl_bank serial_ctrl_bank_chk #(
   .WIDTH((2**ADDR_W)*DATA_W), .DATA_W(DATA_W),
   .MODE_ADDR(MODE_ADDR), .DEFAULTS(DEFAULTS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pwr_lost(pwr_lost), .ser_cs_n(ser_cs_n),
   .regs_flat(regs_flat), .op_mode(op_mode), .pwr_down(pwr_down));

// File: tb/tb_serial_ctrl_bank.sv
module tb_serial_ctrl_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_lost = 1'b0;
   logic        ser_clk = 1'b0;
   logic        ser_dat = 1'b0;
   logic        ser_cs_n = 1'b1;
   logic [63:0] regs_flat;
   logic [1:0]  op_mode;
   logic        pwr_down;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   localparam logic [63:0] DEF = 64'h0000_772B_3A08_0000;
   logic [63:0] exp_regs;

   always #2.5 clk = ~clk;

   serial_ctrl_bank dut (
      .clk(clk), .rst_n(rst_n), .pwr_lost(pwr_lost),
      .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_cs_n(ser_cs_n),
      .regs_flat(regs_flat), .op_mode(op_mode), .pwr_down(pwr_down));

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [1:0] exp_mode(input logic [3:0] r);
      if (r[3])      return 2'd0;
      else if (r[1]) return r[2] ? 2'd3 : 2'd2;
      else if (r[0]) return 2'd0;
      else           return 2'd1;
   endfunction

   task automatic check_all(input string req);
      logic [1:0] em;
      em = exp_mode(exp_regs[55:52]);
      checks++;
      if (regs_flat !== exp_regs) begin
         errors++;
         $display("FAIL %s: regs_flat actual=%h expected=%h", req, regs_flat, exp_regs);
      end
      checks++;
      if (op_mode !== em || pwr_down !== (em == 2'd0)) begin
         errors++;
         $display("FAIL %s: mode/pd actual=%0d/%0b expected=%0d/%0b",
                  req, op_mode, pwr_down, em, (em == 2'd0));
      end
   endtask

   // Sends nbits bits: the first min(nbits,8) come from v MSB first, extras are 0.
   task automatic send(input logic [7:0] v, input int nbits);
      wait_cyc(2);
      ser_cs_n = 1'b0;
      wait_cyc(4);
      for (int i = 0; i < nbits; i++) begin
         ser_dat = (i < 8) ? v[7-i] : 1'b0;
         wait_cyc(4);
         ser_clk = 1'b1;
         wait_cyc(4);
         ser_clk = 1'b0;
      end
      wait_cyc(4);
      ser_cs_n = 1'b1;
      wait_cyc(10);
   endtask

   task automatic write_reg(input logic [3:0] a, input logic [3:0] d);
      send({a, d}, 8);
      exp_regs[a*4 +: 4] = d;
   endtask

   task automatic t_reset;
      exp_regs = DEF;
      check_all("R1");
   endtask

   task automatic t_basic_write;
      write_reg(4'hA, 4'h5);
      check_all("R2");
      write_reg(4'h3, 4'hC);
      check_all("R2");
      write_reg(4'h6, 4'h1);
      check_all("R11");
   endtask

   task automatic t_bad_count;
      send(8'h79, 7);
      check_all("R3");
      send(8'h79, 9);
      check_all("R3");
   endtask

   task automatic t_nop;
      send(8'h0E, 8);
      check_all("R4");
   endtask

   task automatic t_restore;
      write_reg(4'h9, 4'hF);
      send(8'hF6, 8);
      exp_regs = DEF;
      check_all("R5");
   endtask

   task automatic t_pwr_loss;
      write_reg(4'h8, 4'h4);
      write_reg(4'hD, 4'h2);
      check_all("R11");
      // partial frame interrupted by supply loss
      ser_cs_n = 1'b0;
      wait_cyc(4);
      for (int i = 0; i < 4; i++) begin
         ser_dat = 1'b1;
         wait_cyc(4); ser_clk = 1'b1; wait_cyc(4); ser_clk = 1'b0;
      end
      pwr_lost = 1'b1;
      wait_cyc(1);
      pwr_lost = 1'b0;
      for (int i = 0; i < 4; i++) begin
         ser_dat = 1'b0;
         wait_cyc(4); ser_clk = 1'b1; wait_cyc(4); ser_clk = 1'b0;
      end
      wait_cyc(4);
      ser_cs_n = 1'b1;
      wait_cyc(10);
      exp_regs = DEF;
      check_all("R6");
   endtask

   task automatic t_modes;
      for (int v = 0; v < 16; v++) begin
         write_reg(4'hD, 4'(v));
         check_all(v[3] ? "R7" : "R8");
      end
      write_reg(4'hD, 4'h0);
   endtask

   task automatic t_idle_clocks;
      ser_dat = 1'b1;
      for (int i = 0; i < 5; i++) begin
         wait_cyc(4); ser_clk = 1'b1; wait_cyc(4); ser_clk = 1'b0;
      end
      wait_cyc(10);
      check_all("R9");
      write_reg(4'h7, 4'hA);
      check_all("R9");
   endtask

   task automatic t_same_value;
      write_reg(4'h7, 4'hA);
      check_all("R10");
   endtask

   initial begin
      exp_regs = DEF;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(3);
      t_reset();
      t_basic_write();
      t_bad_count();
      t_nop();
      t_restore();
      t_pwr_loss();
      t_modes();
      t_idle_clocks();
      t_same_value();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule